// File: doc/BRIEF.md
# SMRAM Address Redirection Decoder

This block sits in the system logic between the bus masters and memory. For every physical access it decides whether the cycle is served by the system-management RAM or by ordinary system RAM. It bases that choice on four things: the address, whether the requester is the CPU or another master such as DMA, whether the CPU is in system-management mode, and a software-controlled overlay switch. The overlay switch lets the handler image be written into SMRAM while the CPU is still running normally.

A small region at 38000h–3FFFFh is always treated as SMRAM. A second window, with a configurable base and a power-of-two size from 32 KB up to 4 GB, can widen the decoded area. Inside that region, a 512-byte block at 3FE00h–3FFFFh holds the saved processor context, and 38000h is where the handler begins. Each access raises a flag when it lands in either place. The routing result is registered one cycle after the request strobe. A separate combinational path raises a cache-flush request in the same cycle as the management interrupt when the system uses overlaid SMRAM.

Top module: `smram_redirect`

## Requirements
- R1: After reset, and until the first request is taken, rsp_valid is 0, rsp_sel is 2'b00 and both hit flags are 0.
- R2: Addresses 38000h through 3FFFFh are always inside the SMRAM window, whatever the window configuration. 37FFFh and 40000h fall outside it unless the configured window covers them.
- R3: The configured window spans 2^k bytes, where k is win_size_log2 clamped to the range 15..32. Its base is win_base with the low k bits ignored, so a misaligned base selects the aligned block that contains it. With k=32 every address is inside the window.
- R4: While smm_active is 1, a CPU access (req_is_cpu=1) inside the window goes to SMRAM.
- R5: While smm_active is 1, an access from a non-CPU master goes to system RAM even inside the window, and manual_map has no effect.
- R6: While smm_active is 0 and manual_map is 1, any master's access inside the window goes to SMRAM.
- R7: While smm_active is 0 and manual_map is 0, every access goes to system RAM.
- R8: An access outside the window always goes to system RAM.
- R9: rsp_save_hit is 1 only for an access routed to SMRAM whose address lies in 3FE00h–3FFFFh.
- R10: rsp_entry_hit is 1 only for an access routed to SMRAM at address 38000h exactly.
- R11: rsp_sel is one-hot, with bit 1 meaning SMRAM and bit 0 meaning system RAM. It is registered, so a request sampled with req_valid=1 at one clock edge appears with rsp_valid=1 right after that edge. A cycle with no request gives rsp_valid=0 and rsp_sel=2'b00.
- R12: flush_req is smi_pulse AND overlay_mode, combinationally, in the same cycle as smi_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address strobe: a request is present this cycle |
| req_addr | input | 32 | Physical byte address of the request |
| req_is_cpu | input | 1 | 1 when the requester is the CPU, 0 for another master |
| smm_active | input | 1 | CPU is in system-management mode |
| manual_map | input | 1 | Software switch that overlays SMRAM onto system space outside SMM |
| win_base | input | 32 | Base address of the configurable SMRAM window |
| win_size_log2 | input | 6 | log2 of the configurable window size in bytes |
| smi_pulse | input | 1 | Management interrupt request to the CPU |
| overlay_mode | input | 1 | System uses SMRAM overlaid on system memory |
| flush_req | output | 1 | Cache flush request, same cycle as smi_pulse |
| rsp_valid | output | 1 | Registered routing result is valid |
| rsp_sel | output | 2 | One-hot target: bit 1 SMRAM, bit 0 system RAM |
| rsp_save_hit | output | 1 | Access hit the state-save area in SMRAM |
| rsp_entry_hit | output | 1 | Access hit the handler entry address in SMRAM |

## Verification
The bench probes the window edges at 37FFFh, 38000h, 3FDFFh, 3FE00h, 3FFFFh and 40000h. An off-by-one in the fixed range or in the save-area range would send one of these edges to the wrong target or drop a flag. It drives a DMA master during SMM with the overlay switch set, which catches a design that lets manual_map override master identity. It also sets a misaligned window base and size exponents below 15 and above 32, which catch a decoder that skips masking or clamping. Random traffic at window-relative addresses then checks the routing against a bench model for every mix of master, mode and switch.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int unsigned TGT_W = 2;

    localparam logic [TGT_W-1:0] SEL_NONE   = 2'b00;
    localparam logic [TGT_W-1:0] SEL_SYSRAM = 2'b01;
    localparam logic [TGT_W-1:0] SEL_SMRAM  = 2'b10;

    typedef struct packed {
        logic             valid;
        logic [TGT_W-1:0] sel;
        logic             save_hit;
        logic             entry_hit;
    } route_rsp_t;

endpackage

// File: rtl/smram_window_match.sv
module smram_window_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOG2_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [LOG2_W-1:0] size_log2,
    output logic              hit
);

    logic [ADDR_W-1:0] cmp_mask;

    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
            localparam logic [LOG2_W-1:0] BIT_IDX = LOG2_W'(i);
            assign cmp_mask[i] = (BIT_IDX >= size_log2);
        end
    endgenerate

    assign hit = (((addr ^ base) & cmp_mask) == '0);

endmodule

// File: rtl/smram_route_policy.sv
module smram_route_policy
    import smram_pkg::*;
(
    input  logic             in_window,
    input  logic             is_cpu,
    input  logic             smm_active,
    input  logic             manual_map,
    output logic [TGT_W-1:0] sel
);

    logic to_smram;

    always_comb begin
        if (!in_window) begin
            to_smram = 1'b0;
        end else if (smm_active) begin
            to_smram = is_cpu;
        end else begin
            to_smram = manual_map;
        end
        sel = to_smram ? SEL_SMRAM : SEL_SYSRAM;
    end

endmodule

// File: rtl/smram_redirect.sv
module smram_redirect
    import smram_pkg::*;
#(
    parameter int unsigned              ADDR_W     = 32,
    parameter int unsigned              LOG2_W     = 6,
    parameter int unsigned              MIN_LOG2   = 15,
    parameter logic [ADDR_W-1:0]        MIN_BASE   = 32'h0003_8000,
    parameter int unsigned              SAVE_LOG2  = 9,
    parameter logic [ADDR_W-1:0]        SAVE_BASE  = 32'h0003_FE00,
    parameter logic [ADDR_W-1:0]        ENTRY_ADDR = 32'h0003_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_cpu,
    input  logic              smm_active,
    input  logic              manual_map,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [LOG2_W-1:0] win_size_log2,
    input  logic              smi_pulse,
    input  logic              overlay_mode,
    output logic              flush_req,
    output logic              rsp_valid,
    output logic [TGT_W-1:0]  rsp_sel,
    output logic              rsp_save_hit,
    output logic              rsp_entry_hit
);

    localparam logic [LOG2_W-1:0] MIN_K  = LOG2_W'(MIN_LOG2);
    localparam logic [LOG2_W-1:0] MAX_K  = LOG2_W'(ADDR_W);
    localparam logic [LOG2_W-1:0] SAVE_K = LOG2_W'(SAVE_LOG2);

    logic [LOG2_W-1:0] eff_log2;
    logic              hit_fixed;
    logic              hit_cfg;
    logic              hit_save;
    logic [TGT_W-1:0]  route_sel;
    route_rsp_t        rsp_d;
    route_rsp_t        rsp_q;

    always_comb begin
        if (win_size_log2 < MIN_K) begin
            eff_log2 = MIN_K;
        end else if (win_size_log2 > MAX_K) begin
            eff_log2 = MAX_K;
        end else begin
            eff_log2 = win_size_log2;
        end
    end

    smram_window_match #(.ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) u_fixed_win (
        .addr      (req_addr),
        .base      (MIN_BASE),
        .size_log2 (MIN_K),
        .hit       (hit_fixed)
    );

    smram_window_match #(.ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) u_cfg_win (
        .addr      (req_addr),
        .base      (win_base),
        .size_log2 (eff_log2),
        .hit       (hit_cfg)
    );

    smram_window_match #(.ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) u_save_win (
        .addr      (req_addr),
        .base      (SAVE_BASE),
        .size_log2 (SAVE_K),
        .hit       (hit_save)
    );

    smram_route_policy u_policy (
        .in_window  (hit_fixed | hit_cfg),
        .is_cpu     (req_is_cpu),
        .smm_active (smm_active),
        .manual_map (manual_map),
        .sel        (route_sel)
    );

    always_comb begin
        rsp_d = '0;
        rsp_d.sel = SEL_NONE;
        if (req_valid) begin
            rsp_d.valid     = 1'b1;
            rsp_d.sel       = route_sel;
            rsp_d.save_hit  = route_sel[1] & hit_save;
            rsp_d.entry_hit = route_sel[1] & (req_addr == ENTRY_ADDR);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign flush_req     = smi_pulse & overlay_mode;
    assign rsp_valid     = rsp_q.valid;
    assign rsp_sel       = rsp_q.sel;
    assign rsp_save_hit  = rsp_q.save_hit;
    assign rsp_entry_hit = rsp_q.entry_hit;

endmodule

// File: rtl/smram_redirect_chk.sv
module smram_redirect_chk #(
    parameter int unsigned       ADDR_W   = 32,
    parameter int unsigned       MIN_LOG2 = 15,
    parameter logic [ADDR_W-1:0] MIN_BASE = 32'h0003_8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_is_cpu,
    input logic              smm_active,
    input logic              manual_map,
    input logic              smi_pulse,
    input logic              flush_req,
    input logic              rsp_valid,
    input logic [1:0]        rsp_sel,
    input logic              rsp_save_hit,
    input logic              rsp_entry_hit
);

    logic in_fixed;
    assign in_fixed = ((req_addr >> MIN_LOG2) == (MIN_BASE >> MIN_LOG2));

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_sel) == 1));

    // R11
    idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_sel == 2'b00));

    // R11
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4
    smm_cpu_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && smm_active && req_is_cpu && in_fixed) |=> (rsp_sel == 2'b10));

    // R5
    smm_dma_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && smm_active && !req_is_cpu) |=> (rsp_sel == 2'b01));

    // R6
    manual_map_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !smm_active && manual_map && in_fixed) |=> (rsp_sel == 2'b10));

    // R7
    no_map_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !smm_active && !manual_map) |=> (rsp_sel == 2'b01));

    // R9
    save_needs_smram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_save_hit |-> (rsp_valid && rsp_sel[1]));

    // R10
    entry_needs_smram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_entry_hit |-> (rsp_valid && rsp_sel[1]));

    // R12
    flush_with_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> smi_pulse);

endmodule

bind smram_redirect smram_redirect_chk #(
    .ADDR_W   (ADDR_W),
    .MIN_LOG2 (MIN_LOG2),
    .MIN_BASE (MIN_BASE)
) u_chk (.*);

// File: tb/tb_smram_redirect.sv
module tb_smram_redirect;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_is_cpu;
    logic        smm_active;
    logic        manual_map;
    logic [31:0] win_base;
    logic [5:0]  win_size_log2;
    logic        smi_pulse;
    logic        overlay_mode;
    logic        flush_req;
    logic        rsp_valid;
    logic [1:0]  rsp_sel;
    logic        rsp_save_hit;
    logic        rsp_entry_hit;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    smram_redirect dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_is_cpu    (req_is_cpu),
        .smm_active    (smm_active),
        .manual_map    (manual_map),
        .win_base      (win_base),
        .win_size_log2 (win_size_log2),
        .smi_pulse     (smi_pulse),
        .overlay_mode  (overlay_mode),
        .flush_req     (flush_req),
        .rsp_valid     (rsp_valid),
        .rsp_sel       (rsp_sel),
        .rsp_save_hit  (rsp_save_hit),
        .rsp_entry_hit (rsp_entry_hit)
    );

    // Packed as {valid, sel[1:0], save_hit, entry_hit}
    function automatic logic [4:0] model(input logic [31:0] a, input logic cpu,
                                         input logic smm, input logic man,
                                         input logic [31:0] base, input logic [5:0] k);
        int unsigned kk;
        logic [63:0] size, lo, a64;
        logic in_win, smr, save, entry;
        kk = (k < 6'd15) ? 15 : ((k > 6'd32) ? 32 : int'(k));
        size = 64'd1 << kk;
        lo = {32'd0, base} & ~(size - 64'd1);
        a64 = {32'd0, a};
        in_win = ((a64 >= lo) && (a64 < lo + size)) || ((a >= 32'h38000) && (a <= 32'h3FFFF));
        smr = in_win && (smm ? cpu : man);
        save = smr && (a >= 32'h3FE00) && (a <= 32'h3FFFF);
        entry = smr && (a == 32'h38000);
        return {1'b1, smr, !smr, save, entry};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One request: drive at negedge, register at posedge, sample at next negedge.
    task automatic access(input string req, input logic [31:0] a, input logic cpu,
                          input logic smm, input logic man);
        req_valid = 1'b1; req_addr = a; req_is_cpu = cpu;
        smm_active = smm; manual_map = man;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_sel, rsp_save_hit, rsp_entry_hit},
              model(a, cpu, smm, man, win_base, win_size_log2));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_is_cpu = 1'b0;
        smm_active = 1'b0; manual_map = 1'b0; win_base = '0; win_size_log2 = 6'd15;
        smi_pulse = 1'b0; overlay_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {rsp_valid, rsp_sel, rsp_save_hit, rsp_entry_hit}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rsp_valid, rsp_sel, rsp_save_hit, rsp_entry_hit}, 5'b0);

        // R2 fixed window edges, R4 CPU in SMM, R9/R10 flags
        win_base = 32'h0000_0000; win_size_log2 = 6'd15;
        access("R2", 32'h37FFF, 1, 1, 0);
        access("R10", 32'h38000, 1, 1, 0);
        access("R9", 32'h3FDFF, 1, 1, 0);
        access("R9", 32'h3FE00, 1, 1, 0);
        access("R4", 32'h3FFFF, 1, 1, 0);
        access("R2", 32'h40000, 1, 1, 0);
        // R5 DMA in SMM, manual_map ignored
        access("R5", 32'h3FE00, 0, 1, 1);
        access("R5", 32'h38000, 0, 1, 0);
        // R6 manual overlay outside SMM, any master
        access("R6", 32'h38000, 0, 0, 1);
        access("R6", 32'h3FFF0, 1, 0, 1);
        // R7 no map, no SMM
        access("R7", 32'h3FE00, 1, 0, 0);
        // R8 outside window
        access("R8", 32'h1234_5678, 1, 1, 0);

        // R3 misaligned base selects aligned block, size 1 MB
        win_base = 32'h0012_3456; win_size_log2 = 6'd20;
        access("R3", 32'h0010_0000, 1, 1, 0);
        access("R3", 32'h001F_FFFF, 1, 1, 0);
        access("R3", 32'h0020_0000, 1, 1, 0);
        // R3 clamp below 15
        win_base = 32'h0080_0000; win_size_log2 = 6'd3;
        access("R3", 32'h0080_7FFF, 1, 1, 0);
        access("R3", 32'h0080_8000, 1, 1, 0);
        // R3 clamp above 32 -> whole space
        win_size_log2 = 6'd40;
        access("R3", 32'hFFFF_FFFF, 1, 1, 0);
        win_size_log2 = 6'd32;
        access("R3", 32'h0000_0000, 0, 0, 1);

        // R11 no request gives idle output
        @(negedge clk);
        check("R11", {rsp_valid, rsp_sel, rsp_save_hit, rsp_entry_hit}, 5'b0);

        // R12 flush combinational in same cycle
        for (int i = 0; i < 4; i++) begin
            smi_pulse = i[0]; overlay_mode = i[1];
            #1;
            checks++;
            if (flush_req !== (i[0] & i[1])) begin
                errors++;
                $display("FAIL R12: actual=%b expected=%b", flush_req, i[0] & i[1]);
            end
            @(negedge clk);
        end
        smi_pulse = 1'b0; overlay_mode = 1'b0;

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            int unsigned pick;
            if (n % 50 == 0) begin
                win_size_log2 = 6'($urandom_range(10, 34));
                win_base = $urandom();
            end
            pick = $urandom_range(0, 3);
            case (pick)
                0: a = 32'h38000 + 32'($urandom_range(0, 32'h7FFF));
                1: a = 32'h3FE00 + 32'($urandom_range(0, 32'h1FF)) - 32'd4;
                2: a = win_base + 32'($urandom_range(0, 32'hFFFF)) - 32'h8000;
                default: a = $urandom();
            endcase
            if ($urandom_range(0, 1) == 1) begin
                access("R4-model", a, 1'($urandom()), 1'($urandom()), 1'($urandom()));
            end else begin
                @(negedge clk);
                check("R11", {rsp_valid, rsp_sel, rsp_save_hit, rsp_entry_hit}, 5'b0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule